// File: doc/BRIEF.md
# Single-Buffer DMA Channel

This block is one DMA channel that copies one buffer of data from a source area to a destination area. Software programs start addresses, a unit count, a chained-descriptor word, a control word and a configuration word through a word-indexed register port. It then turns on the channel. The channel moves data over a simple memory master port. Each unit takes one read cycle followed by one write cycle.

Either side may be plain memory, which is always ready, or a peripheral. A peripheral side is paced by request lines: one single-unit line and one chunk line for each handshake interface. It can instead be paced by bits in a software request register. Data moves in transactions. At the end of each transaction the channel returns a one-cycle acknowledge to every peripheral side. When the last unit has moved, the channel turns itself off and raises a completion flag. Reading the flag clears it. The flag drives an interrupt line when the flag is unmasked.

Register indices (reg_addr) are as follows:
- 0: source start address
- 1: destination start address
- 2: unit count
- 3: descriptor word
- 4: control
- 5: configuration
- 6: channel-on (write)
- 7: channel status (read)
- 8: global enable
- 9: completion flag
- 10: interrupt mask
- 11: software requests

Top module: `dma_chan_engine`

## Requirements
- R1: Transactions start only while the channel-on bit and bit 0 of register 8 are both 1. The channel-on bit is set by writing 1 to bit 0 of register 6. Writing 0 there has no effect.
- R2: Bit 0 of register 7 reads 1 while the channel is on. It reads 0 when the channel is idle and available.
- R3: Bit 0 of register 9 is set when the buffer completes, and a read of register 9 clears it. irq is 1 exactly when that flag and bit 0 of register 10 are both 1.
- R4: Register 3 is stored and read back. The channel never fetches a descriptor, so no memory request follows buffer completion.
- R5: Configuration bit 0 (source) and bit 1 (destination) select the request source for a peripheral side. A value of 1 selects the hardware request lines. A value of 0 selects register 11: bit 0 is source single, bit 1 is source chunk, bit 2 is destination single and bit 3 is destination chunk. The unselected request source is ignored.
- R6: Configuration bits [3:2] give the source handshake index and bits [5:4] give the destination handshake index. The index picks the bit of hw_sreq, hw_creq and hw_ack that the side uses.
- R7: Control bits [1:0] set the source width and bits [3:2] set the destination width: 0 is byte, 1 is halfword, 2 is word. mem_size carries the width of each access.
- R8: Control bits [5:4] set the source address mode and bits [7:6] set the destination address mode: 0 increments, 1 decrements, 2 holds the address fixed. The step is that side's width in bytes.
- R9: Control bit 8 marks the source as a peripheral and bit 9 marks the destination as a peripheral. A memory side needs no request.
- R10: A transaction starts once every peripheral side has a request pending. It is CHUNK units long if any peripheral side asked for a chunk, or if both sides are memory. Otherwise it is 1 unit long. The length is cut to the units left. After its last write, each hardware-paced peripheral side gets a one-cycle hw_ack, and the software request bits of each peripheral side are cleared.
- R11: Register 2 counts source-width units. After the acknowledge cycle of the transaction that moves the last unit, the channel-on bit clears and the completion flag sets.
- R12: Writes to registers 0 to 5 are ignored while the channel is on.
- R13: Each unit is a read cycle followed by a write cycle to the destination. The write data is the source unit, right-aligned on the bus and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears flag on register 9) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| hw_sreq | input | NPER | Single-unit request lines |
| hw_creq | input | NPER | Chunk request lines |
| hw_ack | output | NPER | Transaction acknowledge pulses |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the clock edge that ends its cycle. The first read request appears in the cycle after the edge at which the channel is on, enabled and seeing every side ready. Each write follows its read by exactly one cycle. hw_ack is high in the cycle after the last write of a transaction. The status, flag and irq changes land at the edge that ends that acknowledge cycle. The bench builds the expected list of memory beats behaviourally and compares every request cycle against it at the falling edge. It counts the writes between acknowledges to check transaction lengths, and reads status and flags through the register port only after those due edges.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_ACK} dma_state_e;

    localparam logic [3:0] RIX_SRC   = 4'd0;
    localparam logic [3:0] RIX_DST   = 4'd1;
    localparam logic [3:0] RIX_SIZE  = 4'd2;
    localparam logic [3:0] RIX_DESC  = 4'd3;
    localparam logic [3:0] RIX_CTRL  = 4'd4;
    localparam logic [3:0] RIX_CFG   = 4'd5;
    localparam logic [3:0] RIX_CHON  = 4'd6;
    localparam logic [3:0] RIX_STAT  = 4'd7;
    localparam logic [3:0] RIX_GEN   = 4'd8;
    localparam logic [3:0] RIX_FLAG  = 4'd9;
    localparam logic [3:0] RIX_MASK  = 4'd10;
    localparam logic [3:0] RIX_SWREQ = 4'd11;

    localparam logic [1:0] AM_INC = 2'd0;
    localparam logic [1:0] AM_DEC = 2'd1;

    localparam int CTRL_W = 10;

    // lanes covered by a unit of the given width code
    function automatic logic [31:0] unit_mask(input logic [1:0] w);
        case (w)
            2'd0:    unit_mask = 32'h0000_00FF;
            2'd1:    unit_mask = 32'h0000_FFFF;
            default: unit_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    width,
    input  logic [1:0]    mode,
    output logic [AW-1:0] addr_nx
);
    import dma_chan_pkg::*;

    logic [AW-1:0] step;

    always_comb begin
        step = (width == 2'd0) ? AW'(1) : (width == 2'd1) ? AW'(2) : AW'(4);
        case (mode)
            AM_INC:  addr_nx = addr + step;
            AM_DEC:  addr_nx = addr - step;
            default: addr_nx = addr;
        endcase
    end
endmodule

// File: rtl/dma_side_req.sv
module dma_side_req #(
    parameter int NPER = 4,
    localparam int PW = (NPER > 1) ? $clog2(NPER) : 1
) (
    input  logic            is_periph,
    input  logic            hw_sel,
    input  logic [PW-1:0]   per_idx,
    input  logic [NPER-1:0] hw_sreq,
    input  logic [NPER-1:0] hw_creq,
    input  logic            sw_single,
    input  logic            sw_chunk,
    output logic            ready,
    output logic            chunk
);
    logic line_s, line_c;

    always_comb begin
        line_s = hw_sel ? hw_sreq[per_idx] : sw_single;
        line_c = hw_sel ? hw_creq[per_idx] : sw_chunk;
        ready  = !is_periph || line_s || line_c;
        chunk  = is_periph && line_c;
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
    parameter int AW     = 16,
    parameter int SIZE_W = 12,
    parameter int NPER   = 4,
    parameter int CHUNK  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic [NPER-1:0] hw_sreq,
    input  logic [NPER-1:0] hw_creq,
    output logic [NPER-1:0] hw_ack,
    output logic            irq
);
    import dma_chan_pkg::*;

    localparam int PW    = (NPER > 1) ? $clog2(NPER) : 1;
    localparam int BW    = $clog2(CHUNK + 1);
    localparam int CFG_W = 2 + 2 * PW;

    typedef struct packed {
        dma_state_e        st;
        logic [AW-1:0]     src_p;
        logic [AW-1:0]     dst_p;
        logic [AW-1:0]     desc_p;
        logic [AW-1:0]     src_a;
        logic [AW-1:0]     dst_a;
        logic [SIZE_W-1:0] size_p;
        logic [SIZE_W-1:0] cnt;
        logic [BW-1:0]     beats;
        logic [CTRL_W-1:0] ctrl;
        logic [CFG_W-1:0]  cfg;
        logic              ch_en;
        logic              glb;
        logic              flag;
        logic              mask;
        logic [3:0]        swreq;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]    side_rdy, side_chk;
    logic [AW-1:0] src_nx, dst_nx;
    logic [BW-1:0] want_len, take_len;
    logic          both_mem;

    // per-side request selection: g=0 source, g=1 destination
    for (genvar g = 0; g < 2; g++) begin : g_side
        dma_side_req #(.NPER(NPER)) u_side (
            .is_periph (r_q.ctrl[8+g]),
            .hw_sel    (r_q.cfg[g]),
            .per_idx   (r_q.cfg[2+g*PW +: PW]),
            .hw_sreq   (hw_sreq),
            .hw_creq   (hw_creq),
            .sw_single (r_q.swreq[2*g]),
            .sw_chunk  (r_q.swreq[2*g+1]),
            .ready     (side_rdy[g]),
            .chunk     (side_chk[g])
        );
    end

    dma_addr_step #(.AW(AW)) u_src_step (
        .addr(r_q.src_a), .width(r_q.ctrl[1:0]), .mode(r_q.ctrl[5:4]), .addr_nx(src_nx)
    );
    dma_addr_step #(.AW(AW)) u_dst_step (
        .addr(r_q.dst_a), .width(r_q.ctrl[3:2]), .mode(r_q.ctrl[7:6]), .addr_nx(dst_nx)
    );

    always_comb begin
        both_mem = !r_q.ctrl[8] && !r_q.ctrl[9];
        want_len = (both_mem || (|side_chk)) ? BW'(CHUNK) : BW'(1);
        take_len = (r_q.cnt < SIZE_W'(want_len)) ? BW'(r_q.cnt) : want_len;
    end

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                RIX_SRC:  if (!r_q.ch_en) r_d.src_p  = reg_wdata[AW-1:0];
                RIX_DST:  if (!r_q.ch_en) r_d.dst_p  = reg_wdata[AW-1:0];
                RIX_SIZE: if (!r_q.ch_en) r_d.size_p = reg_wdata[SIZE_W-1:0];
                RIX_DESC: if (!r_q.ch_en) r_d.desc_p = reg_wdata[AW-1:0];
                RIX_CTRL: if (!r_q.ch_en) r_d.ctrl   = reg_wdata[CTRL_W-1:0];
                RIX_CFG:  if (!r_q.ch_en) r_d.cfg    = reg_wdata[CFG_W-1:0];
                RIX_CHON: if (reg_wdata[0] && !r_q.ch_en) begin
                    r_d.ch_en = 1'b1;
                    r_d.src_a = r_q.src_p;
                    r_d.dst_a = r_q.dst_p;
                    r_d.cnt   = r_q.size_p;
                end
                RIX_GEN:   r_d.glb   = reg_wdata[0];
                RIX_MASK:  r_d.mask  = reg_wdata[0];
                RIX_SWREQ: r_d.swreq = r_q.swreq | reg_wdata[3:0];
                default: ;
            endcase
        end
        if (reg_re && reg_addr == RIX_FLAG) r_d.flag = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (r_q.ch_en && r_q.glb) begin
                    if (r_q.cnt == '0) begin
                        r_d.ch_en = 1'b0;
                        r_d.flag  = 1'b1;
                    end else if (&side_rdy) begin
                        r_d.beats = take_len;
                        r_d.st    = ST_RD;
                    end
                end
            end
            ST_RD: r_d.st = ST_WR;
            ST_WR: begin
                r_d.src_a = src_nx;
                r_d.dst_a = dst_nx;
                r_d.cnt   = r_q.cnt - 1'b1;
                r_d.beats = r_q.beats - 1'b1;
                r_d.st    = (r_q.beats == BW'(1)) ? ST_ACK : ST_RD;
            end
            default: begin
                if (r_q.ctrl[8]) r_d.swreq[1:0] = 2'b00;
                if (r_q.ctrl[9]) r_d.swreq[3:2] = 2'b00;
                if (r_q.cnt == '0) begin
                    r_d.ch_en = 1'b0;
                    r_d.flag  = 1'b1;
                end
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req   = (r_q.st == ST_RD) || (r_q.st == ST_WR);
        mem_we    = (r_q.st == ST_WR);
        mem_addr  = (r_q.st == ST_WR) ? r_q.dst_a : r_q.src_a;
        mem_size  = (r_q.st == ST_WR) ? r_q.ctrl[3:2] : r_q.ctrl[1:0];
        mem_wdata = mem_rdata & unit_mask(r_q.ctrl[1:0]);
        irq       = r_q.flag && r_q.mask;
        hw_ack    = '0;
        if (r_q.st == ST_ACK) begin
            if (r_q.ctrl[8] && r_q.cfg[0]) hw_ack[r_q.cfg[2 +: PW]] = 1'b1;
            if (r_q.ctrl[9] && r_q.cfg[1]) hw_ack[r_q.cfg[2+PW +: PW]] = 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RIX_SRC:   reg_rdata = 32'(r_q.src_p);
            RIX_DST:   reg_rdata = 32'(r_q.dst_p);
            RIX_SIZE:  reg_rdata = 32'(r_q.size_p);
            RIX_DESC:  reg_rdata = 32'(r_q.desc_p);
            RIX_CTRL:  reg_rdata = 32'(r_q.ctrl);
            RIX_CFG:   reg_rdata = 32'(r_q.cfg);
            RIX_STAT:  reg_rdata = {31'b0, r_q.ch_en};
            RIX_GEN:   reg_rdata = {31'b0, r_q.glb};
            RIX_FLAG:  reg_rdata = {31'b0, r_q.flag};
            RIX_MASK:  reg_rdata = {31'b0, r_q.mask};
            RIX_SWREQ: reg_rdata = {28'b0, r_q.swreq};
            default:   reg_rdata = '0;
        endcase
    end

    // state exposed to the bound checker
    logic          en_now, glb_now, flag_now;
    logic [AW-1:0] src_prog_now;
    assign en_now       = r_q.ch_en;
    assign glb_now      = r_q.glb;
    assign flag_now     = r_q.flag;
    assign src_prog_now = r_q.src_p;

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
    parameter int AW   = 16,
    parameter int NPER = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_we,
    input logic [NPER-1:0] hw_ack,
    input logic            en_now,
    input logic            glb_now,
    input logic            flag_now,
    input logic [AW-1:0]   src_prog_now
);
    assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(en_now && glb_now));

    assert_write_after_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));

    assert_ack_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_ack) |=> !(|hw_ack));

    assert_ack_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|hw_ack) |-> $past(mem_req && mem_we));

    assert_done_turns_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_now) |-> !en_now);

    assert_prog_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_now && $past(en_now)) |-> $stable(src_prog_now));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .NPER(NPER)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .hw_ack       (hw_ack),
    .en_now       (en_now),
    .glb_now      (glb_now),
    .flag_now     (flag_now),
    .src_prog_now (src_prog_now)
);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;
    localparam int AW = 16, SIZE_W = 12, NPER = 4, CHUNK = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic [31:0] mem_wdata, mem_rdata;
    logic [NPER-1:0] hw_sreq = '0, hw_creq = '0, hw_ack;
    logic irq;

    dma_chan_engine #(.AW(AW), .SIZE_W(SIZE_W), .NPER(NPER), .CHUNK(CHUNK)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .hw_sreq(hw_sreq), .hw_creq(hw_creq), .hw_ack(hw_ack), .irq(irq)
    );

    int errors = 0, checks = 0, wr_count = 0, req_count = 0, cycles = 0;
    logic [7:0] mem [0:1023];

    typedef struct packed { logic we; logic [AW-1:0] a; logic [1:0] sz; logic [31:0] d; } beat_t;
    beat_t expq[$];
    beat_t e;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic int nbytes(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] unit_at(input int a, input logic [1:0] w);
        logic [31:0] v = '0;
        for (int k = 0; k < nbytes(w); k++) v |= 32'(pat(a + k)) << (8 * k);
        return v;
    endfunction

    function automatic logic [31:0] mem_unit(input int a, input logic [1:0] w);
        logic [31:0] v = '0;
        for (int k = 0; k < nbytes(w); k++) v |= 32'(mem[(a + k) & 1023]) << (8 * k);
        return v;
    endfunction

    function automatic int step(input int a, input logic [1:0] w, input logic [1:0] m);
        if (m == 2'd0) return (a + nbytes(w)) & 32'hFFFF;
        if (m == 2'd1) return (a - nbytes(w)) & 32'hFFFF;
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: read data valid in the cycle after the read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (!mem_we) mem_rdata <= mem_unit(int'(mem_addr), mem_size);
            else for (int k = 0; k < nbytes(mem_size); k++)
                mem[(int'(mem_addr) + k) & 1023] <= mem_wdata[8*k +: 8];
        end
    end

    // bus monitor against the behavioural beat list, plus watchdog
    always @(negedge clk) begin
        cycles++;
        if (rst_n && mem_req) begin
            req_count++;
            if (mem_we) wr_count++;
            if (expq.size() == 0) begin
                chk(1'b0, "R4", "unexpected memory request", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
                e = expq.pop_front();
                chk(mem_we == e.we, "R13", "beat direction", 32'(mem_we), 32'(e.we));
                chk(mem_addr == e.a, "R8", "beat address", 32'(mem_addr), 32'(e.a));
                chk(mem_size == e.sz, "R7", "beat width", 32'(mem_size), 32'(e.sz));
                if (e.we) chk(mem_wdata == e.d, "R13", "write data", mem_wdata, e.d);
            end
        end
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_re = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_xfer(input int src, input int dst, input logic [1:0] sw, input logic [1:0] dw,
                             input logic [1:0] sm, input logic [1:0] dm, input int n);
        int sa = src, da = dst;
        for (int i = 0; i < n; i++) begin
            expq.push_back('{1'b0, AW'(sa), sw, 32'h0});
            expq.push_back('{1'b1, AW'(da), dw, unit_at(sa, sw)});
            sa = step(sa, sw, sm);
            da = step(da, dw, dm);
        end
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v = 32'h1;
        for (int t = 0; t < 500 && v[0]; t++) rd(4'd7, v);
        chk(v == 0, req, "channel turns off after buffer", v, 0);
        chk(expq.size() == 0, req, "all expected beats issued", 32'(expq.size()), 0);
    endtask

    task automatic hs(input int idx, input bit chunk, input int exp_beats);
        int w0 = wr_count;
        bit seen = 1'b0;
        @(negedge clk);
        if (chunk) hw_creq[idx] = 1'b1; else hw_sreq[idx] = 1'b1;
        for (int t = 0; t < 200 && !seen; t++) begin
            @(negedge clk);
            if (hw_ack[idx]) begin
                seen = 1'b1;
                chk(hw_ack == NPER'(1 << idx), "R6", "ack on selected line only", 32'(hw_ack), 32'(1 << idx));
                hw_creq = '0; hw_sreq = '0;
            end
        end
        chk(seen, "R10", "acknowledge returned", 32'(seen), 1);
        chk(wr_count - w0 == exp_beats, "R10", "transaction length", 32'(wr_count - w0), 32'(exp_beats));
    endtask

    task automatic sw_hs(input logic [3:0] bits, input int exp_beats);
        int w0 = wr_count;
        logic [31:0] v = 32'hF;
        wr(4'd11, 32'(bits));
        for (int t = 0; t < 100 && v != 0; t++) rd(4'd11, v);
        chk(v == 0, "R10", "software request cleared by ack", v, 0);
        chk(wr_count - w0 == exp_beats, "R5", "software transaction length", 32'(wr_count - w0), 32'(exp_beats));
    endtask

    initial begin
        logic [31:0] v;
        int r0;
        bit ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(4'd7, v);  chk(v == 0, "R2", "status after reset", v, 0);
        rd(4'd9, v);  chk(v == 0, "R3", "flag after reset", v, 0);
        rd(4'd0, v);  chk(v == 0, "R12", "source register after reset", v, 0);
        chk(irq == 0 && mem_req == 0, "R3", "outputs quiet after reset", {30'b0, irq, mem_req}, 0);

        // T1: word copy memory to memory, gated by global enable
        wr(4'd0, 32'h100); wr(4'd1, 32'h200); wr(4'd2, 4); wr(4'd3, 32'h3C0);
        wr(4'd4, 32'h00A); wr(4'd5, 0); wr(4'd10, 1);
        rd(4'd3, v); chk(v == 32'h3C0, "R4", "descriptor readback", v, 32'h3C0);
        wr(4'd6, 1);
        rd(4'd7, v); chk(v == 1, "R2", "status while on", v, 1);
        r0 = req_count; idle(10);
        chk(req_count == r0, "R1", "no transfer without global enable", 32'(req_count - r0), 0);
        wr(4'd0, 32'h55);
        rd(4'd0, v); chk(v == 32'h100, "R12", "source write ignored while on", v, 32'h100);
        wr(4'd6, 0);
        rd(4'd7, v); chk(v == 1, "R1", "writing 0 keeps channel on", v, 1);
        push_xfer(32'h100, 32'h200, 2'd2, 2'd2, 2'd0, 2'd0, 4);
        wr(4'd8, 1);
        wait_done("R11");
        chk(irq == 1, "R3", "irq with mask set", 32'(irq), 1);
        rd(4'd9, v); chk(v == 1, "R3", "flag set at completion", v, 1);
        rd(4'd9, v); chk(v == 0, "R3", "flag cleared by read", v, 0);
        chk(irq == 0, "R3", "irq drops after read", 32'(irq), 0);
        ok = 1'b1;
        for (int k = 0; k < 16; k++) if (mem[32'h200 + k] != pat(32'h100 + k)) ok = 1'b0;
        chk(ok, "R13", "destination words copied", 32'(ok), 1);
        r0 = req_count; idle(20);
        chk(req_count == r0, "R4", "no descriptor fetch after buffer", 32'(req_count - r0), 0);

        // T2: byte source decrementing to halfword destination, mask off
        wr(4'd10, 0);
        wr(4'd0, 32'h30A); wr(4'd1, 32'h280); wr(4'd2, 5); wr(4'd4, 32'h14);
        push_xfer(32'h30A, 32'h280, 2'd0, 2'd1, 2'd1, 2'd0, 5);
        wr(4'd6, 1);
        wait_done("R8");
        chk(irq == 0, "R3", "irq masked", 32'(irq), 0);
        rd(4'd9, v); chk(v == 1, "R3", "flag set though masked", v, 1);
        ok = 1'b1;
        for (int i = 0; i < 5; i++)
            if (mem[32'h280 + 2*i] != pat(32'h30A - i) || mem[32'h281 + 2*i] != 8'h00) ok = 1'b0;
        chk(ok, "R7", "bytes zero-extended into halfwords", 32'(ok), 1);

        // T3: source is a hardware-paced peripheral on line 2, fixed address
        wr(4'd10, 1);
        wr(4'd0, 32'h340); wr(4'd1, 32'h2C0); wr(4'd2, 6);
        wr(4'd4, 32'h12A); wr(4'd5, 32'h9);
        push_xfer(32'h340, 32'h2C0, 2'd2, 2'd2, 2'd2, 2'd0, 6);
        wr(4'd6, 1);
        r0 = req_count; idle(6);
        chk(req_count == r0, "R9", "peripheral side waits for request", 32'(req_count - r0), 0);
        hs(2, 1'b1, 4);
        hs(2, 1'b0, 1);
        hs(2, 1'b1, 1);
        wait_done("R11");
        rd(4'd9, v); chk(v == 1, "R11", "flag after peripheral buffer", v, 1);

        // T4: destination is a software-paced peripheral, halfword source
        wr(4'd0, 32'h380); wr(4'd1, 32'h2F0); wr(4'd2, 5);
        wr(4'd4, 32'h289); wr(4'd5, 32'h0);
        push_xfer(32'h380, 32'h2F0, 2'd1, 2'd2, 2'd0, 2'd2, 5);
        wr(4'd6, 1);
        @(negedge clk); hw_creq = '1; hw_sreq = '1;
        r0 = req_count; idle(8);
        chk(req_count == r0, "R5", "hardware lines ignored when software selected", 32'(req_count - r0), 0);
        hw_creq = '0; hw_sreq = '0;
        sw_hs(4'h8, 4);
        sw_hs(4'h4, 1);
        wait_done("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule